// File: doc/BRIEF.md
# Saturating Channel Step Unit

This unit executes a step command on the 14-bit input value of one converter channel. A command word has three parts: a 2-bit register-select code, an 8-bit channel address and a 14-bit data field. A strobe marks the cycle in which the command is valid. When the select code is 00, the unit reads the stored value of the addressed channel through a combinational read port. It then adds or subtracts a 7-bit step, and one cycle later it presents the result with a write-back enable. The result saturates at either end of the 14-bit range and never wraps.

The select code 00 is also used by the soft reset command. When the select code is 00 and all fourteen data bits are 1, the command is a soft reset. The unit raises a one-cycle soft-reset flag in that case and writes nothing back. The channel register file is outside this unit. It answers the read port in the same cycle and takes the write-back when the enable is high.

Top module: `incdec_unit`

## Requirements
- R1: While rst_ni is low, wb_en_o and soft_rst_o are 0, and wb_addr_o and wb_data_o are 0.
- R2: Only a strobed command whose select code is 00 has any effect. Codes 01, 10 and 11 produce neither a write-back nor a soft-reset flag.
- R3: When data bit 8 is 1, the write-back value is the stored value plus the step in data bits 6..0. A result above 16383 is replaced by 16383 (3FFF hex).
- R4: When data bit 8 is 0, the write-back value is the stored value minus the step. A result below 0 is replaced by 0.
- R5: A step of 0 writes back the stored value unchanged, in both directions.
- R6: A command with select code 00 and data equal to 3FFF hex raises soft_rst_o for one cycle and does not assert wb_en_o.
- R7: Data bits 13..9 and bit 7 do not affect the result of a step command. The only exception is the all-ones word of R6.
- R8: An address equal to or greater than NUM_CH produces no write-back. A lower address is written back on wb_addr_o unchanged.
- R9: wb_en_o and soft_rst_o go high exactly one clock cycle after the strobed command, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Command valid this cycle |
| reg_sel_i | input | 2 | Register-select code |
| addr_i | input | ADDR_W | Channel address |
| data_i | input | 14 | Data field: step in bits 6..0, direction in bit 8 |
| rd_addr_o | output | ADDR_W | Read address to the channel register file |
| rd_data_i | input | 14 | Stored value of the channel on rd_addr_o |
| wb_en_o | output | 1 | Write-back enable |
| wb_addr_o | output | ADDR_W | Write-back channel |
| wb_data_o | output | 14 | Write-back value |
| soft_rst_o | output | 1 | Soft-reset command detected |

## Verification
The bench sweeps every step in both directions over stored values at and near both ends of the range. A design that wraps would return small values close to full scale, or values close to full scale after an underflow. It fills the ignored data bits with random junk, and it sends the all-ones word under every select code. A design that decoded soft reset loosely, or let junk bits into the step, would write back wrong data or raise the flag by mistake. It also walks all 256 addresses, because a design with a wrong range compare would write to channels that do not exist. After each command it checks that the outputs fall back to 0 on the next cycle, which catches outputs held high for more than one cycle.

// File: rtl/incdec_pkg.sv
package incdec_pkg;
  localparam int DATA_W  = 14;
  localparam int STEP_W  = 7;
  localparam int DIR_BIT = 8;
  localparam logic [1:0] SEL_STEP = 2'b00;
  typedef logic [DATA_W-1:0] chan_val_t;
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/incdec_decode.sv
module incdec_decode
  import incdec_pkg::*;
#(
  parameter int NUM_CH = 40,
  parameter int ADDR_W = 8
) (
  input  logic              strobe_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  chan_val_t         data_i,
  output logic              step_hit_o,
  output logic              srst_hit_o,
  output step_t             step_o,
  output logic              up_o
);
  localparam logic [ADDR_W:0] CH_LIMIT = (ADDR_W+1)'(NUM_CH);

  logic sel_ok, all_ones, addr_ok;

  assign sel_ok     = strobe_i && (reg_sel_i == SEL_STEP);
  assign all_ones   = &data_i;
  assign addr_ok    = {1'b0, addr_i} < CH_LIMIT;
  assign srst_hit_o = sel_ok && all_ones;
  assign step_hit_o = sel_ok && !all_ones && addr_ok;
  assign step_o     = data_i[STEP_W-1:0];
  assign up_o       = data_i[DIR_BIT];
endmodule

// File: rtl/incdec_sat_step.sv
module incdec_sat_step
  import incdec_pkg::*;
(
  input  chan_val_t val_i,
  input  step_t     step_i,
  input  logic      up_i,
  output chan_val_t res_o
);
  logic [DATA_W:0] ext_val, ext_step, sum, diff;

  assign ext_val  = {1'b0, val_i};
  assign ext_step = {{(DATA_W+1-STEP_W){1'b0}}, step_i};
  assign sum      = ext_val + ext_step;
  assign diff     = ext_val - ext_step;

  // bit DATA_W flags a carry out on the add or a borrow on the subtract
  always_comb begin
    if (up_i) res_o = sum[DATA_W]  ? '1 : sum[DATA_W-1:0];
    else      res_o = diff[DATA_W] ? '0 : diff[DATA_W-1:0];
  end
endmodule

// File: rtl/incdec_unit.sv
module incdec_unit
  import incdec_pkg::*;
#(
  parameter int NUM_CH = 40,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              soft_rst_o
);
  localparam logic [ADDR_W:0] CH_LIMIT = (ADDR_W+1)'(NUM_CH);

  logic      step_hit, srst_hit, up;
  step_t     step;
  chan_val_t res;

  assign rd_addr_o = addr_i;

  incdec_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .strobe_i  (strobe_i),
    .reg_sel_i (reg_sel_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .step_hit_o(step_hit),
    .srst_hit_o(srst_hit),
    .step_o    (step),
    .up_o      (up)
  );

  incdec_sat_step u_sat (
    .val_i (rd_data_i),
    .step_i(step),
    .up_i  (up),
    .res_o (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o    <= 1'b0;
      soft_rst_o <= 1'b0;
      wb_addr_o  <= '0;
      wb_data_o  <= '0;
    end else begin
      wb_en_o    <= step_hit;
      soft_rst_o <= srst_hit;
      if (step_hit) begin
        wb_addr_o <= addr_i;
        wb_data_o <= res;
      end
    end
  end

  // R6: the two results never occur together
  a_r6_srst_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_en_o && soft_rst_o));
  a_r6_srst_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(strobe_i) && $past(reg_sel_i) == SEL_STEP && $past(&data_i));
  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> $past(strobe_i) && $past(reg_sel_i) == SEL_STEP);
  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> ({1'b0, wb_addr_o} < CH_LIMIT));
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && $past(data_i[DIR_BIT]) |-> wb_data_o >= $past(rd_data_i));
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && !$past(data_i[DIR_BIT]) |-> wb_data_o <= $past(rd_data_i));
  a_r5_zero_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && $past(data_i[STEP_W-1:0]) == '0 |-> wb_data_o == $past(rd_data_i));
endmodule

// File: tb/incdec_unit_test.sv
`timescale 1ns/1ps
module incdec_unit_test;
  localparam int NCH = 8;
  localparam int MAXV = 16383;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [7:0]  addr = '0;
  logic [13:0] data = '0;
  logic [7:0]  rd_addr;
  logic [13:0] rd_data;
  logic        wb_en, srst;
  logic [7:0]  wb_addr;
  logic [13:0] wb_data;
  logic [13:0] mem [NCH];

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign rd_data = (rd_addr < 8'(NCH)) ? mem[rd_addr[2:0]] : 14'h0;

  incdec_unit #(.NUM_CH(NCH), .ADDR_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .reg_sel_i(sel),
    .addr_i(addr), .data_i(data), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wb_en_o(wb_en), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .soft_rst_o(srst)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic [7:0] a, input logic [13:0] d);
    bit e_srst, e_wb;
    int v, st, e_val;
    e_srst = (s == 2'b00) && (d == 14'h3FFF);
    e_wb   = (s == 2'b00) && !e_srst && (a < 8'(NCH));
    v      = (a < 8'(NCH)) ? int'(mem[a[2:0]]) : 0;
    st     = int'(d[6:0]);
    if (d[8]) e_val = (v + st > MAXV) ? MAXV : v + st;
    else      e_val = (v - st < 0) ? 0 : v - st;
    @(negedge clk);
    strobe = 1'b1; sel = s; addr = a; data = d;
    @(negedge clk);
    strobe = 1'b0;
    sel = 2'($urandom); data = 14'($urandom);
    check("R2/R8 wb_en", int'(wb_en), int'(e_wb));
    check("R6 soft_rst", int'(srst), int'(e_srst));
    if (e_wb) begin
      check("R8 wb_addr", int'(wb_addr), int'(a));
      check(d[8] ? "R3 inc value" : "R4 dec value", int'(wb_data), e_val);
    end
    @(negedge clk);
    check("R9 wb_en pulse", int'(wb_en), 0);
    check("R9 soft_rst pulse", int'(srst), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int vals [12] = '{0, 1, 2, 63, 64, 126, 127, 128, 8192, 16256, 16382, 16383};
    foreach (mem[i]) mem[i] = 14'(i * 1000);
    #12;
    // R1 reset state
    check("R1 wb_en", int'(wb_en), 0);
    check("R1 soft_rst", int'(srst), 0);
    check("R1 wb_addr", int'(wb_addr), 0);
    check("R1 wb_data", int'(wb_data), 0);
    rst_n = 1'b1;

    // R3 R4 R5 R7: all steps, both directions, near both ends, junk in ignored bits
    foreach (vals[k]) begin
      for (int st = 0; st < 128; st++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [2:0] ch;
          logic [4:0] junk_hi;
          logic       junk7;
          ch = 3'(k + st);
          junk_hi = (st[0]) ? 5'($urandom) : 5'h0;
          junk7   = (st[1]) ? 1'($urandom) : 1'b0;
          mem[ch] = 14'(vals[k]);
          apply(2'b00, {5'h0, ch}, {junk_hi, dir[0], junk7, st[6:0]});
        end
      end
    end

    // R6 soft reset on every select code, including a channel beyond range
    for (int s = 0; s < 4; s++) begin
      apply(2'(s), 8'd3, 14'h3FFF);
      apply(2'(s), 8'd200, 14'h3FFF);
    end
    // R6 near misses of all-ones are ordinary steps
    mem[2] = 14'd16000;
    apply(2'b00, 8'd2, 14'h3FFE);
    apply(2'b00, 8'd2, 14'h3EFF);

    // R2 other select codes ignored
    for (int s = 1; s < 4; s++) begin
      mem[5] = 14'd500;
      apply(2'(s), 8'd5, 14'h0105);
      apply(2'(s), 8'd5, 14'h0005);
    end

    // R8 address walk
    for (int a = 0; a < 256; a++) begin
      if (a < NCH) mem[a] = 14'd100;
      apply(2'b00, 8'(a), 14'h0101);
    end

    // R9 back-to-back strobes: each command answered on the following cycle
    mem[1] = 14'd10;
    @(negedge clk);
    strobe = 1'b1; sel = 2'b00; addr = 8'd1; data = 14'h0103;
    @(negedge clk);
    check("R9 first wb_en", int'(wb_en), 1);
    check("R9 first wb_data", int'(wb_data), 13);
    data = 14'h0005;
    @(negedge clk);
    strobe = 1'b0;
    check("R9 second wb_en", int'(wb_en), 1);
    check("R9 second wb_data", int'(wb_data), 5);
    @(negedge clk);
    check("R9 idle wb_en", int'(wb_en), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule